// File: doc/BRIEF.md
# Glitch-Free System Clock Switcher

This block chooses which of up to eight oscillator inputs drives the system clock. It also produces a divided enable strobe on that clock. Software selects a source through a small register port: it writes the wanted source code and sets a start bit in the same write.

The controller first checks the ready input of the wanted source. If that source is not ready, the request is refused and the active source stays as it was. If the source is ready, the controller hands the output over without glitches:

- Each source has its own enable cell, clocked on that source's falling edge.
- The new source is switched on only after the old source's enable has gone low.

The register port always shows the active source, which can differ from the requested one. An external monitor can pulse a failure input; this sets a sticky flag that software later clears.

The post-divider runs in the domain of the selected clock. A one-cycle strobe `sys_en` marks every (N+1)-th output cycle. Divider changes cross into that domain through a toggle handshake, and a busy flag is set while a change is in flight. With slewing enabled for the direction of the change, the ratio moves by one per step. Each intermediate ratio lasts a programmed number of strobes.

Top module: `sysclk_switch`

## Requirements
- R1: After reset:
  - the control register (`wr_sel`/`rd_sel` = 0) reads 0: active source 0, requested source 0, start bit 0, failure flag 0;
  - the slew register (`wr_sel`/`rd_sel` = 1) reads 0;
  - `clk_out` follows source 0.
- R2: A write to either register while `unlock` is low changes nothing: the read-back values and `clk_out` stay the same.
- R3: A control write carrying bit 0 = 1 and a source code in bits 10:8 starts a switch. If that source is ready, bits 14:12 then read the new code, bit 0 returns to 0, and `clk_out` runs at that source's period. Requesting the already active source only clears bit 0.
- R4: If the requested source's ready input is low, bit 0 returns to 0, bits 14:12 keep the old code, bits 10:8 keep the requested code, and `clk_out` is unchanged.
- R5: During a handover, no high or low phase of `clk_out` is shorter than the shortest half period of any source input. At no time are two source enables active together.
- R6: A pulse on `fail_pulse` sets control bit 2, which stays set. A control write with bit 2 = 1 clears it. If a pulse and a clearing write arrive in the same cycle, the flag ends up set.
- R7: With slew-register bits 23:20 = N in effect, `sys_en` is high for one `clk_out` cycle out of every N+1. Bits 23:20 read back the requested N.
- R8: An accepted slew write that changes bits 23:20 makes bit 0 read 1 from the next cycle until the new ratio is in effect. Slew writes made while bit 0 is 1 are ignored.
- R9: When the ratio must rise and bit 2 is 1, or must fall and bit 1 is 1, the ratio moves by exactly one per step. Every intermediate ratio lasts (S+1) strobes, where S is in bits 10:8.
- R10: When the slew bit for the direction of a change is 0, the ratio jumps straight to the target with no intermediate ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlock | input | 1 | Register writes take effect only while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 slew |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 slew |
| rd_data | output | 32 | Read data of the selected register |
| src_clk | input | NSRC | Oscillator clock inputs |
| src_ready | input | NSRC | Per-source ready indications |
| fail_pulse | input | 1 | Failure event from the clock monitor |
| clk_out | output | 1 | Selected system clock |
| sys_en | output | 1 | Post-divider strobe in the `clk_out` domain |

## Verification
Two functions can land in the same control-clock cycle:
- the monitor setting the failure flag;
- software clearing that flag.

The bench provokes the clash by asserting `fail_pulse` and a clearing control write on the same falling clock edge. It then judges the read-back: the flag must still be set.

A second overlap occurs when a slew write arrives one cycle after another, while the first is still busy. It is judged by reading back the first target and measuring the final strobe spacing.

// File: rtl/sysclk_sw_pkg.sv
`timescale 1ns/1ps
package sysclk_sw_pkg;
  // control register bit positions
  localparam int CTL_GO_BIT   = 0;
  localparam int CTL_FAIL_BIT = 2;
  localparam int CTL_REQ_LSB  = 8;
  localparam int CTL_ACT_LSB  = 12;
  // slew register bit positions
  localparam int SLW_BUSY_BIT = 0;
  localparam int SLW_DN_BIT   = 1;
  localparam int SLW_UP_BIT   = 2;
  localparam int SLW_STEP_LSB = 8;
  localparam int SLW_DIV_LSB  = 20;

  typedef enum logic {SW_IDLE, SW_WAIT} sw_state_e;
endpackage

// File: rtl/sysclk_sw_rst_sync.sv
`timescale 1ns/1ps
module sysclk_sw_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sysclk_sw_gf_cell.sv
`timescale 1ns/1ps
module sysclk_sw_gf_cell #(
  parameter bit START_ON = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  output logic en_o
);
  logic meta_q, en_q;

  // falling-edge stages: the enable only moves while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= START_ON;
      en_q   <= START_ON;
    end else begin
      meta_q <= want_i;
      en_q   <= meta_q;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/sysclk_sw_ctrl.sv
`timescale 1ns/1ps
module sysclk_sw_ctrl
  import sysclk_sw_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 4,
  parameter int STEP_W    = 3,
  parameter int RESET_SRC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              rd_sel,
  output logic [31:0]       rd_data,
  input  logic [NSRC-1:0]   src_ready,
  input  logic              fail_pulse,
  input  logic [NSRC-1:0]   en_vec,
  output logic [NSRC-1:0]   sel_oh,
  output logic [DIV_W-1:0]  div_tgt,
  output logic              slew_up,
  output logic              slew_dn,
  output logic [STEP_W-1:0] slew_step,
  output logic              req_tgl,
  input  logic              ack_tgl
);
  localparam logic [NSRC-1:0]  RST_OH  = NSRC'(1) << RESET_SRC;
  localparam logic [SRC_W-1:0] RST_SRC = SRC_W'(RESET_SRC);

  sw_state_e         st_q, st_d;
  logic              go_q, go_d, fail_q, fail_d;
  logic [SRC_W-1:0]  req_src_q, req_src_d, act_q, act_d;
  logic [NSRC-1:0]   sel_q, sel_d;
  logic [NSRC-1:0]   rdy_s1_q, rdy_s2_q, en_s1_q, en_s2_q;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              up_q, up_d, dn_q, dn_d, tgl_q, tgl_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        ack_s_q;
  logic              ctl_wr, slw_wr, busy;
  logic              unused_wr;

  assign ctl_wr    = wr_en & unlock & ~wr_sel;
  assign slw_wr    = wr_en & unlock &  wr_sel;
  assign busy      = tgl_q ^ ack_s_q[1];
  assign unused_wr = ^wr_data;

  always_comb begin
    st_d      = st_q;
    go_d      = go_q;
    fail_d    = fail_q;
    req_src_d = req_src_q;
    act_d     = act_q;
    sel_d     = sel_q;
    div_d     = div_q;
    up_d      = up_q;
    dn_d      = dn_q;
    step_d    = step_q;
    tgl_d     = tgl_q;
    if (ctl_wr && wr_data[CTL_FAIL_BIT]) fail_d = 1'b0;
    if (fail_pulse)                      fail_d = 1'b1;
    if (ctl_wr && st_q == SW_IDLE && !go_q) begin
      req_src_d = wr_data[CTL_REQ_LSB +: SRC_W];
      go_d      = wr_data[CTL_GO_BIT];
    end
    case (st_q)
      SW_IDLE: if (go_q) begin
        if (req_src_q == act_q) begin
          go_d = 1'b0;
        end else if (rdy_s2_q[req_src_q]) begin
          sel_d = NSRC'(1) << req_src_q;
          st_d  = SW_WAIT;
        end else begin
          go_d = 1'b0;
        end
      end
      SW_WAIT: if (en_s2_q == sel_q) begin
        act_d = req_src_q;
        go_d  = 1'b0;
        st_d  = SW_IDLE;
      end
      default: st_d = SW_IDLE;
    endcase
    if (slw_wr && !busy) begin
      div_d  = wr_data[SLW_DIV_LSB +: DIV_W];
      up_d   = wr_data[SLW_UP_BIT];
      dn_d   = wr_data[SLW_DN_BIT];
      step_d = wr_data[SLW_STEP_LSB +: STEP_W];
      if (wr_data[SLW_DIV_LSB +: DIV_W] != div_q) tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SW_IDLE;
      go_q      <= 1'b0;
      fail_q    <= 1'b0;
      req_src_q <= RST_SRC;
      act_q     <= RST_SRC;
      sel_q     <= RST_OH;
      rdy_s1_q  <= '0;
      rdy_s2_q  <= '0;
      en_s1_q   <= RST_OH;
      en_s2_q   <= RST_OH;
      div_q     <= '0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      step_q    <= '0;
      tgl_q     <= 1'b0;
      ack_s_q   <= 2'b00;
    end else begin
      st_q      <= st_d;
      go_q      <= go_d;
      fail_q    <= fail_d;
      req_src_q <= req_src_d;
      act_q     <= act_d;
      sel_q     <= sel_d;
      rdy_s1_q  <= src_ready;
      rdy_s2_q  <= rdy_s1_q;
      en_s1_q   <= en_vec;
      en_s2_q   <= en_s1_q;
      div_q     <= div_d;
      up_q      <= up_d;
      dn_q      <= dn_d;
      step_q    <= step_d;
      tgl_q     <= tgl_d;
      ack_s_q   <= {ack_s_q[0], ack_tgl};
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_sel) begin
      rd_data[CTL_GO_BIT]             = go_q;
      rd_data[CTL_FAIL_BIT]           = fail_q;
      rd_data[CTL_REQ_LSB +: SRC_W]   = req_src_q;
      rd_data[CTL_ACT_LSB +: SRC_W]   = act_q;
    end else begin
      rd_data[SLW_BUSY_BIT]           = busy;
      rd_data[SLW_DN_BIT]             = dn_q;
      rd_data[SLW_UP_BIT]             = up_q;
      rd_data[SLW_STEP_LSB +: STEP_W] = step_q;
      rd_data[SLW_DIV_LSB +: DIV_W]   = div_q;
    end
  end

  assign sel_oh    = sel_q;
  assign div_tgt   = div_q;
  assign slew_up   = up_q;
  assign slew_dn   = dn_q;
  assign slew_step = step_q;
  assign req_tgl   = tgl_q;

  // R4
  reject_keeps_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_IDLE && go_q && req_src_q != act_q && !rdy_s2_q[req_src_q])
    |=> (!go_q && $stable(act_q)));
  // R3
  act_moves_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(st_q) == SW_WAIT));
  // R5
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_vec));
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> fail_q);
  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock) |=> ($stable(req_src_q) && $stable(div_q)));
  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_sel) |=> $stable(div_q));
endmodule

// File: rtl/sysclk_sw_postdiv.sv
`timescale 1ns/1ps
module sysclk_sw_postdiv #(
  parameter int DIV_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [DIV_W-1:0]  tgt_i,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              ack_tgl_o,
  output logic              sys_en_o
);
  logic [2:0]        rq_q;
  logic              pend_q, pend_d, ack_q, ack_d;
  logic              up_l_q, up_l_d, dn_l_q, dn_l_d;
  logic [DIV_W-1:0]  tgt_l_q, tgt_l_d, cur_q, cur_d, cnt_q, cnt_d;
  logic [STEP_W-1:0] step_l_q, step_l_d, hold_q, hold_d;
  logic              strobe, new_req, go_up, go_dn;

  assign strobe  = (cnt_q == cur_q);
  assign new_req = rq_q[2] ^ rq_q[1];
  assign go_up   = (tgt_l_q > cur_q) & up_l_q;
  assign go_dn   = (tgt_l_q < cur_q) & dn_l_q;

  always_comb begin
    cnt_d    = strobe ? '0 : cnt_q + 1'b1;
    pend_d   = pend_q;
    ack_d    = ack_q;
    up_l_d   = up_l_q;
    dn_l_d   = dn_l_q;
    tgt_l_d  = tgt_l_q;
    step_l_d = step_l_q;
    cur_d    = cur_q;
    hold_d   = hold_q;
    if (new_req) begin
      pend_d   = 1'b1;
      tgt_l_d  = tgt_i;
      up_l_d   = up_i;
      dn_l_d   = dn_i;
      step_l_d = step_i;
      hold_d   = '0;
    end else if (pend_q && strobe) begin
      if (cur_q == tgt_l_q) begin
        pend_d = 1'b0;
        ack_d  = ~ack_q;
      end else if (go_up || go_dn) begin
        if (hold_q == step_l_q) begin
          cur_d  = go_up ? cur_q + 1'b1 : cur_q - 1'b1;
          hold_d = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end else begin
        cur_d = tgt_l_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_q     <= 3'b000;
      pend_q   <= 1'b0;
      ack_q    <= 1'b0;
      up_l_q   <= 1'b0;
      dn_l_q   <= 1'b0;
      tgt_l_q  <= '0;
      step_l_q <= '0;
      cur_q    <= '0;
      cnt_q    <= '0;
      hold_q   <= '0;
    end else begin
      rq_q     <= {rq_q[1:0], req_tgl_i};
      pend_q   <= pend_d;
      ack_q    <= ack_d;
      up_l_q   <= up_l_d;
      dn_l_q   <= dn_l_d;
      tgt_l_q  <= tgt_l_d;
      step_l_q <= step_l_d;
      cur_q    <= cur_d;
      cnt_q    <= cnt_d;
      hold_q   <= hold_d;
    end
  end

  assign ack_tgl_o = ack_q;
  assign sys_en_o  = strobe;

  // R9
  slew_up_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_l_q) && (cur_q > $past(cur_q))) |-> (cur_q == $past(cur_q) + 1'b1));
  // R9
  slew_dn_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dn_l_q) && (cur_q < $past(cur_q))) |-> (cur_q == $past(cur_q) - 1'b1));
  // R7
  strobe_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |=> (cnt_q == '0));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch #(
  parameter int NSRC      = 8,
  parameter int DIV_W     = 4,
  parameter int STEP_W    = 3,
  parameter int RESET_SRC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unlock,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [31:0]     wr_data,
  input  logic            rd_sel,
  output logic [31:0]     rd_data,
  input  logic [NSRC-1:0] src_clk,
  input  logic [NSRC-1:0] src_ready,
  input  logic            fail_pulse,
  output logic            clk_out,
  output logic            sys_en
);
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic              rst_c_n, rst_o_n;
  logic [NSRC-1:0]   sel_oh, want, en_vec;
  logic [DIV_W-1:0]  div_tgt;
  logic [STEP_W-1:0] slew_step;
  logic              slew_up, slew_dn, req_tgl, ack_tgl;

  sysclk_sw_rst_sync u_rst_ctl (.clk_i(clk), .rst_ni(rst_n), .rst_no(rst_c_n));

  sysclk_sw_ctrl #(
    .NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .STEP_W(STEP_W), .RESET_SRC(RESET_SRC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_c_n), .unlock(unlock), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .src_ready(src_ready),
    .fail_pulse(fail_pulse), .en_vec(en_vec), .sel_oh(sel_oh), .div_tgt(div_tgt),
    .slew_up(slew_up), .slew_dn(slew_dn), .slew_step(slew_step),
    .req_tgl(req_tgl), .ack_tgl(ack_tgl)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic            rst_s_n;
    logic [NSRC-1:0] others_on;
    sysclk_sw_rst_sync u_rst_src (.clk_i(src_clk[g]), .rst_ni(rst_n), .rst_no(rst_s_n));
    assign others_on = en_vec & ~(NSRC'(1) << g);
    assign want[g]   = sel_oh[g] & ~(|others_on);
    sysclk_sw_gf_cell #(.START_ON(g == RESET_SRC)) u_cell (
      .clk_i(src_clk[g]), .rst_ni(rst_s_n), .want_i(want[g]), .en_o(en_vec[g])
    );
  end

  assign clk_out = |(src_clk & en_vec);

  sysclk_sw_rst_sync u_rst_out (.clk_i(clk_out), .rst_ni(rst_n), .rst_no(rst_o_n));

  sysclk_sw_postdiv #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_div (
    .clk_i(clk_out), .rst_ni(rst_o_n), .req_tgl_i(req_tgl), .tgt_i(div_tgt),
    .up_i(slew_up), .dn_i(slew_dn), .step_i(slew_step),
    .ack_tgl_o(ack_tgl), .sys_en_o(sys_en)
  );
endmodule

// File: tb/sysclk_switch_tb_top.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
  localparam int NSRC = 8;

  logic            clk, rst_n, unlock, wr_en, wr_sel, rd_sel, fail_pulse;
  logic [31:0]     wr_data, rd_data;
  logic [NSRC-1:0] src_clk, src_ready;
  logic            clk_out, sys_en;
  logic            sclk_a [NSRC];

  int  n_total = 0, n_bad = 0;
  bit  done = 0;
  bit  mon_on = 0;
  int  viol = 0, edges = 0;
  real last_t = 0.0;
  int  gap_a [512];
  int  gap_n = 0, gap_cnt = 0;

  sysclk_switch dut_i (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .src_clk(src_clk),
    .src_ready(src_ready), .fail_pulse(fail_pulse), .clk_out(clk_out), .sys_en(sys_en)
  );

  initial begin clk = 0; forever #2 clk = ~clk; end

  // source g has period 6+2g ns
  for (genvar g = 0; g < NSRC; g++) begin : g_osc
    initial begin sclk_a[g] = 0; forever #(3.0 + g) sclk_a[g] = ~sclk_a[g]; end
    assign src_clk[g] = sclk_a[g];
  end

  // phase-width monitor on the output clock
  always @(clk_out) begin
    if (mon_on) begin
      if ($realtime - last_t < 2.99) viol++;
      edges++;
    end
    last_t = $realtime;
  end

  // strobe spacing logger in clk_out cycles
  always @(negedge clk_out) begin
    if (rst_n) begin
      gap_cnt++;
      if (sys_en) begin
        if (gap_n < 512) begin gap_a[gap_n] = gap_cnt; gap_n++; end
        gap_cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_hex(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: act=0x%08h exp=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int data, input bit unl);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data; unlock = unl;
    @(negedge clk);
    wr_en = 0; unlock = 0;
  endtask

  task automatic rd(input bit sel, output int v);
    @(negedge clk);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic period(output int ps);
    real t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); ps = int'(($realtime - t0) * 1000.0);
  endtask

  task automatic wait_clear(input bit sel, input string req);
    int v = 1;
    for (int i = 0; i < 3000 && v[0]; i++) rd(sel, v);
    chk(v[0] == 0, req, "bit0 never cleared", v[0], 0);
  endtask

  task automatic wait_strobes(input int n);
    for (int i = 0; i < 20000 && gap_n < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    int v, p;
    rd(0, v); chk_hex("R1", "control after reset", v, 0);
    rd(1, v); chk_hex("R1", "slew after reset", v, 0);
    period(p); chk(p == 6000, "R1", "clk_out period ps", p, 6000);
  endtask

  task automatic t_locked();
    int v, p;
    wr(0, 32'h0000_0101, 0);
    rd(0, v); chk_hex("R2", "locked control write", v, 0);
    repeat (100) @(negedge clk);
    period(p); chk(p == 6000, "R2", "period after locked write", p, 6000);
    wr(1, 32'h0050_0000, 0);
    rd(1, v); chk_hex("R2", "locked slew write", v, 0);
  endtask

  task automatic do_switch(input int src, input int exp_act, input string req);
    int v, p;
    wr(0, (src << 8) | 1, 1);
    wait_clear(0, req);
    rd(0, v); chk_hex(req, "control after switch", v, (exp_act << 12) | (src << 8));
    period(p); chk(p == (6 + 2 * exp_act) * 1000, req, "clk_out period ps", p, (6 + 2 * exp_act) * 1000);
  endtask

  task automatic t_switch();
    do_switch(2, 2, "R3");
    do_switch(5, 5, "R3");
    do_switch(5, 5, "R3");
  endtask

  task automatic t_reject();
    do_switch(3, 5, "R4");
    do_switch(6, 5, "R4");
  endtask

  task automatic t_glitch();
    chk(viol == 0, "R5", "short phases on clk_out", viol, 0);
    chk(edges > 100, "R5", "monitored edges", edges, 101);
    do_switch(7, 7, "R3");
    do_switch(0, 0, "R3");
    chk(viol == 0, "R5", "short phases after return", viol, 0);
  endtask

  task automatic t_fail();
    int v;
    @(negedge clk); fail_pulse = 1;
    @(negedge clk); fail_pulse = 0;
    rd(0, v); chk_hex("R6", "flag set by pulse", v, 4);
    wr(0, 0, 1);
    rd(0, v); chk_hex("R6", "write without clear bit", v, 4);
    wr(0, 4, 1);
    rd(0, v); chk_hex("R6", "flag cleared", v, 0);
    @(negedge clk);
    fail_pulse = 1; wr_en = 1; wr_sel = 0; wr_data = 4; unlock = 1;
    @(negedge clk);
    fail_pulse = 0; wr_en = 0; unlock = 0;
    rd(0, v); chk_hex("R6", "set wins over clear", v, 4);
    wr(0, 4, 1);
  endtask

  task automatic t_div_jump();
    int v, bad;
    gap_n = 0;
    wr(1, 5 << 20, 1);
    rd(1, v); chk_hex("R8", "busy after write", v, 32'h0050_0001);
    wait_clear(1, "R8");
    bad = 0;
    for (int i = 0; i < gap_n; i++) if (gap_a[i] != 1 && gap_a[i] != 6) bad++;
    chk(bad == 0, "R10", "intermediate spacings", bad, 0);
    gap_n = 0; wait_strobes(20);
    bad = 0;
    for (int i = 0; i < gap_n; i++) if (gap_a[i] != 6) bad++;
    chk(bad == 0 && gap_n >= 20, "R7", "spacing 6 for N=5", bad, 0);
    wr(1, 2 << 20, 1);
    wr(1, 7 << 20, 1);
    wait_clear(1, "R8");
    rd(1, v); chk_hex("R8", "write while busy ignored", v, 32'h0020_0000);
    gap_n = 0; wait_strobes(10);
    chk(gap_a[9] == 3, "R7", "spacing for N=2", gap_a[9], 3);
    wr(1, 0, 1);
    wait_clear(1, "R10");
  endtask

  task automatic t_slew_up();
    int v, c2 = 0, c3 = 0, bad = 0, stop;
    gap_n = 0;
    wr(1, (3 << 20) | (1 << 8) | 4, 1);
    wait_clear(1, "R9");
    stop = gap_n + 10; wait_strobes(stop);
    for (int i = 0; i < gap_n; i++) begin
      if (gap_a[i] == 2) c2++;
      if (gap_a[i] == 3) c3++;
      if (i > 0 && gap_a[i] != gap_a[i-1] && gap_a[i] != gap_a[i-1] + 1) bad++;
    end
    chk(bad == 0, "R9", "rising unit steps", bad, 0);
    chk(c2 == 2, "R9", "strobes at ratio 2", c2, 2);
    chk(c3 == 2, "R9", "strobes at ratio 3", c3, 2);
    chk(gap_a[gap_n-1] == 4, "R9", "final ratio", gap_a[gap_n-1], 4);
    rd(1, v); chk_hex("R7", "slew readback", v, 32'h0030_0104);
  endtask

  task automatic t_slew_dn();
    int c2 = 0, c3 = 0, bad = 0, stop;
    gap_n = 0;
    wr(1, (2 << 8) | 2, 1);
    wait_clear(1, "R9");
    stop = gap_n + 10; wait_strobes(stop);
    for (int i = 0; i < gap_n; i++) begin
      if (gap_a[i] == 2) c2++;
      if (gap_a[i] == 3) c3++;
      if (i > 0 && gap_a[i] != gap_a[i-1] && gap_a[i] != gap_a[i-1] - 1) bad++;
    end
    chk(bad == 0, "R9", "falling unit steps", bad, 0);
    chk(c3 == 3, "R9", "strobes at ratio 3", c3, 3);
    chk(c2 == 3, "R9", "strobes at ratio 2", c2, 3);
    chk(gap_a[gap_n-1] == 1, "R9", "final ratio", gap_a[gap_n-1], 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_total++; n_bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; unlock = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    fail_pulse = 0;
    src_ready = 8'b1011_0111;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (20) @(negedge clk);
    mon_on = 1;
    t_reset();
    t_locked();
    t_switch();
    t_reject();
    t_glitch();
    t_fail();
    t_div_jump();
    t_slew_up();
    t_slew_dn();
    finish_run();
  end
endmodule